// File: doc/BRIEF.md
# Capture-Reload Up-Down Timer

A 16-bit timer/counter with one 16-bit holding register that serves both as a capture latch and as a reload value. Software reaches the block through a small byte-wide register bus. Through that bus it selects the count source, the reload or capture behaviour and the clocking mode, and it presets the count and holding registers. Two external pins feed the block: a trigger pin and a count pin. Both pass through synchronisers and edge detectors on the system clock.

The trigger pin has three roles, chosen by the mode bits. In capture mode it is a capture strobe. In auto-reload mode it is a reload strobe. When up/down counting is enabled it sets the count direction. The baud-generator and clock-out modes override the capture selection: the counter then reloads only on overflow, and it advances every second system clock. The baud-generator mode emits a one-cycle tick on each overflow. The clock-out mode toggles a pin on each overflow. Two sticky flags record overflows and trigger events until software clears them.

Top module: `cru_timer`

## Requirements
- R1: After reset, every register reads 0x00 and ovf_flag, ext_flag, baud_tick and clk_out are all 0.
- R2: The bus registers are: address 0 is control, 1 is mode, 2 is count low byte, 3 is count high byte, 4 is hold low byte, 5 is hold high byte. The control bits are: bit0 capture select, bit1 run, bit2 trigger enable, bit3 count-pin source, bit4 transmit-clock select, bit5 receive-clock select, bit6 external flag, bit7 overflow flag. The mode bits are: bit0 up/down enable and bit1 clock-out enable. Mode bits 7..2 are not stored and read as 0.
- R3: With run set and no fast mode active, the count advances once every 12 system clocks. If the count-pin source bit is set, it instead advances once for each falling edge of count_pin.
- R4: In capture mode (capture select 1, no fast mode), a falling edge on trig_pin with trigger enable set copies the count into the hold register and sets ext_flag.
- R5: In reload mode (capture select 0, or any fast mode), counting up past 0xFFFF loads the hold value and sets ovf_flag. In capture mode the count wraps to 0x0000 and sets ovf_flag.
- R6: In reload mode without up/down, a falling edge on trig_pin with trigger enable set loads the hold value into the count and sets ext_flag.
- R7: With up/down enabled in reload mode, trig_pin high makes the timer count up and trig_pin low makes it count down.
- R8: When counting down, a step taken while the count equals the hold value loads 0xFFFF and sets ovf_flag.
- R9: When either clock select bit is set (baud mode), the count advances every 2 system clocks and reloads on overflow whatever the capture select bit is. Each overflow gives a one-cycle baud_tick, and ovf_flag is not set. trig_pin has no effect on the count or the hold register.
- R10: With clock-out enabled, the count advances every 2 system clocks, and each overflow reloads the count and toggles clk_out.
- R11: Both flags stay set until software writes the control register. With trigger enable clear, a trig_pin edge neither changes the registers nor sets ext_flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| trig_pin | input | 1 | Trigger pin: capture strobe, reload strobe or direction |
| count_pin | input | 1 | External count input |
| ovf_flag | output | 1 | Sticky overflow flag (control bit7) |
| ext_flag | output | 1 | Sticky trigger-event flag (control bit6) |
| baud_tick | output | 1 | One-cycle pulse per overflow in baud mode |
| clk_out | output | 1 | Clock-out pin, toggles per overflow |

## Verification
The counting path is tried with a table of start counts, hold values and trigger levels. The entries separate a reload to the hold value from a wrap to zero, an up step from a down step, an underflow on the hold value from an ordinary decrement, and a step every 12 clocks from a step every 2. Directed tests then strobe the trigger pin in capture, reload and baud settings, which shows whether a copy, a load or nothing follows. Further tests pulse the count pin, and measure the spacing of the baud tick and of the clock-out edges for a hold value of 0xFFF0.

// File: rtl/cru_timer_pkg.sv
package cru_timer_pkg;

  typedef enum logic [2:0] {
    REG_CTRL   = 3'd0,
    REG_MODE   = 3'd1,
    REG_CNT_LO = 3'd2,
    REG_CNT_HI = 3'd3,
    REG_CAP_LO = 3'd4,
    REG_CAP_HI = 3'd5
  } reg_addr_e;

  // control register, bit7 first
  typedef struct packed {
    logic ovf;
    logic ext;
    logic rx_clk;
    logic tx_clk;
    logic cnt_sel;
    logic ext_en;
    logic run;
    logic cap_sel;
  } ctrl_t;

  typedef struct packed {
    logic clkout_en;
    logic dir_en;
  } mode_t;

endpackage

// File: rtl/cru_sync_edge.sv
module cru_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic level_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign level_o = sync_q[STAGES-1];
  assign fall_o  = last_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/cru_prescale.sv
module cru_prescale #(
  parameter int SLOW_DIV = 12,
  parameter int FAST_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic fast_sel,
  output logic tick
);
  localparam int PW = $clog2(SLOW_DIV + 1);
  localparam logic [PW-1:0] SLOW_LIM = PW'(SLOW_DIV - 1);
  localparam logic [PW-1:0] FAST_LIM = PW'(FAST_DIV - 1);

  logic [PW-1:0] div_q;
  logic [PW-1:0] lim;

  assign lim  = fast_sel ? FAST_LIM : SLOW_LIM;
  assign tick = enable && (div_q >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       div_q <= '0;
    else if (!enable) div_q <= '0;
    else if (tick)    div_q <= '0;
    else              div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/cru_count_core.sv
module cru_count_core #(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step,
  input  logic               up,
  input  logic               reload_mode,
  input  logic               ext_load,
  input  logic               ext_cap,
  input  logic               cnt_wr_lo,
  input  logic               cnt_wr_hi,
  input  logic               cap_wr_lo,
  input  logic               cap_wr_hi,
  input  logic [CNT_W/2-1:0] wdata,
  output logic [CNT_W-1:0]   cnt_q,
  output logic [CNT_W-1:0]   cap_q,
  output logic               ovf_evt
);
  localparam int HW = CNT_W / 2;

  // boundary of the current direction
  function automatic logic hit_limit(logic dir_up, logic [CNT_W-1:0] c,
                                     logic [CNT_W-1:0] r);
    return dir_up ? (c == {CNT_W{1'b1}}) : (c == r);
  endfunction

  // value taken after crossing the boundary
  function automatic logic [CNT_W-1:0] wrap_value(logic dir_up, logic rl,
                                                  logic [CNT_W-1:0] r);
    if (!dir_up) return {CNT_W{1'b1}};
    return rl ? r : '0;
  endfunction

  function automatic logic [CNT_W-1:0] step_value(logic dir_up,
                                                  logic [CNT_W-1:0] c);
    return dir_up ? c + 1'b1 : c - 1'b1;
  endfunction

  assign ovf_evt = step && !ext_load && hit_limit(up, cnt_q, cap_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_wr_lo || cnt_wr_hi) begin
      if (cnt_wr_lo) cnt_q[HW-1:0]     <= wdata;
      if (cnt_wr_hi) cnt_q[CNT_W-1:HW] <= wdata;
    end else if (ext_load) begin
      cnt_q <= cap_q;
    end else if (ovf_evt) begin
      cnt_q <= wrap_value(up, reload_mode, cap_q);
    end else if (step) begin
      cnt_q <= step_value(up, cnt_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= '0;
    end else if (cap_wr_lo || cap_wr_hi) begin
      if (cap_wr_lo) cap_q[HW-1:0]     <= wdata;
      if (cap_wr_hi) cap_q[CNT_W-1:HW] <= wdata;
    end else if (ext_cap) begin
      cap_q <= cnt_q;
    end
  end
endmodule

// File: rtl/cru_timer.sv
module cru_timer
  import cru_timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int TIMER_DIV   = 12,
  parameter int BAUD_DIV    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [2:0]         bus_addr,
  input  logic [CNT_W/2-1:0] bus_wdata,
  output logic [CNT_W/2-1:0] bus_rdata,
  input  logic               trig_pin,
  input  logic               count_pin,
  output logic               ovf_flag,
  output logic               ext_flag,
  output logic               baud_tick,
  output logic               clk_out
);
  localparam int HW     = CNT_W / 2;
  localparam int N_PINS = 2;

  ctrl_t            ctrl_q;
  mode_t            mode_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cap_q;
  logic             baud_tick_q;
  logic             clk_out_q;

  // pin synchronisers: index 0 trigger, index 1 count
  logic [N_PINS-1:0] pin_raw, pin_lvl, pin_fall;
  assign pin_raw = {count_pin, trig_pin};

  for (genvar g = 0; g < N_PINS; g++) begin : g_pin
    cru_sync_edge #(.STAGES(SYNC_STAGES)) i_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (pin_raw[g]),
      .level_o(pin_lvl[g]),
      .fall_o (pin_fall[g])
    );
  end

  // mode decode, named for the checker
  logic baud_mode, fast_mode, reload_mode, capture_mode, updown, count_up;
  logic clkout_en, presc_en, presc_tick, step;
  logic ext_cap, ext_load, ext_evt, ovf_evt, ctrl_wr;

  assign baud_mode    = ctrl_q.rx_clk | ctrl_q.tx_clk;
  assign clkout_en    = mode_q.clkout_en;
  assign fast_mode    = baud_mode | clkout_en;
  assign reload_mode  = !ctrl_q.cap_sel | fast_mode;
  assign capture_mode = !reload_mode;
  assign updown       = mode_q.dir_en & reload_mode & !fast_mode;
  assign count_up     = !updown | pin_lvl[0];

  assign ext_cap  = pin_fall[0] & ctrl_q.ext_en & capture_mode;
  assign ext_load = pin_fall[0] & ctrl_q.ext_en & reload_mode & !fast_mode & !updown;
  assign ext_evt  = ext_cap | ext_load;

  assign presc_en = ctrl_q.run & (fast_mode | !ctrl_q.cnt_sel);
  assign step     = fast_mode | !ctrl_q.cnt_sel ? presc_tick
                                                 : (ctrl_q.run & pin_fall[1]);

  cru_prescale #(.SLOW_DIV(TIMER_DIV), .FAST_DIV(BAUD_DIV)) i_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (presc_en),
    .fast_sel(fast_mode),
    .tick    (presc_tick)
  );

  cru_count_core #(.CNT_W(CNT_W)) i_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .step       (step),
    .up         (count_up),
    .reload_mode(reload_mode),
    .ext_load   (ext_load),
    .ext_cap    (ext_cap),
    .cnt_wr_lo  (bus_wr && bus_addr == REG_CNT_LO),
    .cnt_wr_hi  (bus_wr && bus_addr == REG_CNT_HI),
    .cap_wr_lo  (bus_wr && bus_addr == REG_CAP_LO),
    .cap_wr_hi  (bus_wr && bus_addr == REG_CAP_HI),
    .wdata      (bus_wdata),
    .cnt_q      (cnt_q),
    .cap_q      (cap_q),
    .ovf_evt    (ovf_evt)
  );

  assign ctrl_wr = bus_wr && bus_addr == REG_CTRL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_wr) begin
      ctrl_q <= ctrl_t'(bus_wdata[7:0]);
    end else begin
      if (ovf_evt && !baud_mode) ctrl_q.ovf <= 1'b1;
      if (ext_evt)               ctrl_q.ext <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= '0;
      baud_tick_q <= 1'b0;
      clk_out_q   <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == REG_MODE) mode_q <= mode_t'(bus_wdata[1:0]);
      baud_tick_q <= ovf_evt & baud_mode;
      if (ovf_evt && clkout_en) clk_out_q <= ~clk_out_q;
    end
  end

  always_comb begin
    case (bus_addr)
      REG_CTRL:   bus_rdata = HW'(ctrl_q);
      REG_MODE:   bus_rdata = HW'(mode_q);
      REG_CNT_LO: bus_rdata = cnt_q[HW-1:0];
      REG_CNT_HI: bus_rdata = cnt_q[CNT_W-1:HW];
      REG_CAP_LO: bus_rdata = cap_q[HW-1:0];
      REG_CAP_HI: bus_rdata = cap_q[CNT_W-1:HW];
      default:    bus_rdata = '0;
    endcase
  end

  assign ovf_flag  = ctrl_q.ovf;
  assign ext_flag  = ctrl_q.ext;
  assign baud_tick = baud_tick_q;
  assign clk_out   = clk_out_q;
endmodule

// File: rtl/cru_timer_chk.sv
module cru_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic [2:0]       bus_addr,
  input logic             step,
  input logic             count_up,
  input logic             reload_mode,
  input logic             baud_mode,
  input logic             clkout_en,
  input logic             ovf_evt,
  input logic             ext_evt,
  input logic             ext_cap,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] cap_q,
  input logic             ovf_flag,
  input logic             baud_tick,
  input logic             clk_out
);
  logic ctrl_wr;
  assign ctrl_wr = bus_wr && bus_addr == 3'd0;

  AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    step && count_up && !ovf_evt && !ext_evt && !bus_wr
    |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1)); // R3

  AST_CAPTURE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    ext_cap && !bus_wr |=> cap_q == $past(cnt_q)); // R4

  AST_TOP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt && reload_mode && cnt_q == '1 && !ext_evt && !bus_wr
    |=> cnt_q == $past(cap_q)); // R5

  AST_EXT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ext_evt && reload_mode && !bus_wr |=> cnt_q == $past(cap_q)); // R6

  AST_BAUD_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    baud_mode && !ovf_flag && !ctrl_wr |=> !ovf_flag); // R9

  AST_BAUD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |=> !baud_tick); // R9

  AST_CLKOUT_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt && clkout_en |=> clk_out != $past(clk_out)); // R10

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag && !ctrl_wr |=> ovf_flag); // R11
endmodule

bind cru_timer cru_timer_chk #(.CNT_W(CNT_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .step       (step),
  .count_up   (count_up),
  .reload_mode(reload_mode),
  .baud_mode  (baud_mode),
  .clkout_en  (clkout_en),
  .ovf_evt    (ovf_evt),
  .ext_evt    (ext_evt),
  .ext_cap    (ext_cap),
  .cnt_q      (cnt_q),
  .cap_q      (cap_q),
  .ovf_flag   (ovf_flag),
  .baud_tick  (baud_tick),
  .clk_out    (clk_out)
);

// File: tb/test_cru_timer.sv
`timescale 1ns/1ps
module test_cru_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       trig_pin = 1'b1;
  logic       count_pin = 1'b1;
  logic       ovf_flag, ext_flag, baud_tick, clk_out;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk; // 125 MHz

  cru_timer i_cru_timer (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .trig_pin(trig_pin),
    .count_pin(count_pin), .ovf_flag(ovf_flag), .ext_flag(ext_flag),
    .baud_tick(baud_tick), .clk_out(clk_out)
  );

  // ctrl, mode, trig level, hold, start, cycles, expected count, expected ovf
  typedef struct packed {
    logic [7:0]  ctrl;
    logic [7:0]  mode;
    logic        trig;
    logic [15:0] hold;
    logic [15:0] start;
    logic [15:0] cycles;
    logic [15:0] exp_cnt;
    logic        exp_ovf;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{8'h02, 8'h00, 1'b1, 16'h1234, 16'hFFFE, 16'd30, 16'h1234, 1'b1}, // R5 reload
    '{8'h03, 8'h00, 1'b1, 16'h1234, 16'hFFFF, 16'd18, 16'h0000, 1'b1}, // R5 wrap
    '{8'h02, 8'h00, 1'b1, 16'h0000, 16'h0010, 16'd40, 16'h0013, 1'b0}, // R3
    '{8'h02, 8'h01, 1'b0, 16'h0100, 16'h0102, 16'd40, 16'hFFFF, 1'b1}, // R7 R8
    '{8'h02, 8'h01, 1'b1, 16'h0100, 16'hFFFF, 16'd18, 16'h0100, 1'b1}, // R7
    '{8'h13, 8'h00, 1'b1, 16'h8000, 16'hFFFE, 16'd7,  16'h8001, 1'b0}, // R9
    '{8'h0A, 8'h00, 1'b1, 16'h0000, 16'h0005, 16'd40, 16'h0005, 1'b0}  // R3 pin idle
  };

  function automatic string vec_tag(int i);
    case (i)
      0, 1:    return "R5";
      2, 6:    return "R3";
      3:       return "R8";
      4:       return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic rd16(logic [2:0] a, output logic [15:0] d);
    logic [7:0] lo, hi;
    rd(a, lo);
    rd(a + 3'd1, hi);
    d = {hi, lo};
  endtask

  task automatic preset(logic [15:0] hold, logic [15:0] cnt);
    wr(3'd0, 8'h00);
    wr(3'd4, hold[7:0]); wr(3'd5, hold[15:8]);
    wr(3'd2, cnt[7:0]);  wr(3'd3, cnt[15:8]);
  endtask

  task automatic trig_fall();
    trig_pin = 1'b0;
    repeat (6) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic trig_restore();
    trig_pin = 1'b1;
    repeat (5) @(posedge clk);
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] w;
    int t0, t1, cyc;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), b);
      check("R1 reg", {8'h00, b}, 16'h0000);
    end
    check("R1 pins", {12'h000, ovf_flag, ext_flag, baud_tick, clk_out}, 16'h0000);

    // R2 unused mode bits
    wr(3'd1, 8'hFF);
    rd(3'd1, b);
    check("R2 mode", {8'h00, b}, 16'h0003);
    wr(3'd1, 8'h00);

    // table walk
    for (int i = 0; i < NV; i++) begin
      wr(3'd0, 8'h00);
      wr(3'd1, VECS[i].mode);
      preset(VECS[i].hold, VECS[i].start);
      trig_pin = VECS[i].trig;
      repeat (5) @(posedge clk);
      wr(3'd0, VECS[i].ctrl);
      repeat (int'(VECS[i].cycles)) @(posedge clk);
      @(negedge clk);
      rd16(3'd2, w);
      check(vec_tag(i), w, VECS[i].exp_cnt);
      check(vec_tag(i), {15'h0, ovf_flag}, {15'h0, VECS[i].exp_ovf});
      wr(3'd0, 8'h00);
      trig_restore();
    end
    wr(3'd1, 8'h00);

    // R4 capture on trigger fall
    preset(16'h0000, 16'hABCD);
    wr(3'd0, 8'h05);
    trig_fall();
    rd16(3'd4, w);
    check("R4 hold", w, 16'hABCD);
    check("R4 flag", {15'h0, ext_flag}, 16'h0001);
    trig_restore();

    // R11 flag cleared by control write, trigger ignored without enable
    wr(3'd0, 8'h01);
    check("R11 clear", {15'h0, ext_flag}, 16'h0000);
    wr(3'd2, 8'h11); wr(3'd3, 8'h11);
    trig_fall();
    rd16(3'd4, w);
    check("R11 hold", w, 16'hABCD);
    check("R11 flag", {15'h0, ext_flag}, 16'h0000);
    trig_restore();

    // R6 external reload
    preset(16'h4321, 16'h0007);
    wr(3'd0, 8'h04);
    trig_fall();
    rd16(3'd2, w);
    check("R6 count", w, 16'h4321);
    check("R6 flag", {15'h0, ext_flag}, 16'h0001);
    trig_restore();

    // R9 trigger ignored in baud mode
    preset(16'h3333, 16'h2222);
    wr(3'd0, 8'h15);
    trig_fall();
    rd16(3'd4, w);
    check("R9 hold", w, 16'h3333);
    rd16(3'd2, w);
    check("R9 count", w, 16'h2222);
    check("R9 flag", {15'h0, ext_flag}, 16'h0000);
    trig_restore();

    // R3 count-pin source
    preset(16'h0000, 16'h00F0);
    wr(3'd0, 8'h0A);
    for (int k = 0; k < 3; k++) begin
      count_pin = 1'b0; repeat (4) @(posedge clk);
      count_pin = 1'b1; repeat (4) @(posedge clk);
    end
    @(negedge clk);
    rd16(3'd2, w);
    check("R3 pin", w, 16'h00F3);

    // R9 baud tick spacing, hold 0xFFF0 -> 16 steps of 2 clocks
    preset(16'hFFF0, 16'hFFF0);
    wr(3'd0, 8'h10 | 8'h02);
    cyc = 0; t0 = -1; t1 = -1;
    while (t1 < 0 && cyc < 400) begin
      @(negedge clk); cyc++;
      if (baud_tick) begin
        if (t0 < 0) t0 = cyc; else t1 = cyc;
      end
    end
    check("R9 period", 16'(t1 - t0), 16'd32);
    check("R9 ovf", {15'h0, ovf_flag}, 16'h0000);

    // R10 clock-out spacing
    preset(16'hFFF0, 16'hFFF0);
    wr(3'd1, 8'h02);
    wr(3'd0, 8'h02);
    cyc = 0; t0 = -1; t1 = -1;
    begin
      logic last;
      last = clk_out;
      while (t1 < 0 && cyc < 400) begin
        @(negedge clk); cyc++;
        if (clk_out != last) begin
          last = clk_out;
          if (t0 < 0) t0 = cyc; else t1 = cyc;
        end
      end
    end
    check("R10 period", 16'(t1 - t0), 16'd32);
    check("R10 ovf", {15'h0, ovf_flag}, 16'h0001);

    // R11 sticky across time
    wr(3'd0, 8'h80);
    repeat (10) @(posedge clk);
    @(negedge clk);
    check("R11 sticky", {15'h0, ovf_flag}, 16'h0001);

    finish_run();
  end
endmodule